// File: doc/BRIEF.md
# Block-Buffered Sample Memory Writer

This block takes a stream of 32-bit sample words and stores them at consecutive byte addresses in a shared memory region. The region holds `MEM_BYTES` bytes and is split into equal buffers of `BUF_BYTES` bytes. Words arrive in frames of `FRAME_WORDS` words. When a word completes a buffer, the block sends a one-cycle event so that a host-side consumer can drain that buffer.

A start strobe captures three values: a base address, a declared region size and the number of buffers to record. If the declared size does not match the region size the block expects, the block refuses to run. Otherwise it writes words until the requested number of buffers is full. The write offset wraps to the start of the region when it reaches the region's end. After the last buffer the block goes idle and shows that it has finished.

Top module: `sample_buf_writer`

## Requirements
- R1: A start strobe whose `cfgSize` differs from `MEM_BYTES` sets `sizeFault` and leaves `running` and `finished` low. No word is written until a valid start is given.
- R2: A start strobe with a correct size and a nonzero `cfgBlocks` latches `cfgBase` and the block count and sets `running`. The first word written after that start goes to `cfgBase`.
- R3: In a cycle with `running` high, `sampleValid` high and `start` low, `memWe` is high, `memData` equals `sampleData`, and `memAddr` equals the latched base plus the current byte offset. The offset then grows by 4.
- R4: The cycle after the word that fills a buffer (every `BUF_BYTES/4` accepted words), `bufEvent` is high for exactly one cycle. It is low in all other cycles.
- R5: After `cfgBlocks` buffers have been filled, `running` falls and `finished` rises in the same cycle as the last event. Later samples are not written.
- R6: When the byte offset reaches `MEM_BYTES`, it returns to 0, so the next word is written at the latched base again.
- R7: `finished` stays high until the next start strobe, and that strobe clears it.
- R8: A valid start with `cfgBlocks` = 0 sets `finished` in the next cycle and writes nothing.
- R9: A start strobe during a run restarts the run: the offset goes to 0, the buffer and frame counts reload, and the new configuration takes effect.
- R10: After reset, `memWe`, `bufEvent`, `running`, `finished` and `sizeFault` are all low.
- R11: A cycle with `sampleValid` low writes nothing and does not move the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latches configuration and begins a run |
| cfgBase | input | 32 | Byte address of the region start |
| cfgSize | input | 32 | Declared region size in bytes |
| cfgBlocks | input | BLK_W | Number of buffers to record |
| sampleValid | input | 1 | A sample word is presented |
| sampleData | input | 32 | Sample word |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 32 | Memory byte address |
| memData | output | 32 | Memory write data |
| bufEvent | output | 1 | One-cycle pulse after a buffer fills |
| running | output | 1 | Run in progress |
| finished | output | 1 | All requested buffers recorded |
| sizeFault | output | 1 | Last start had a wrong size |

## Verification
Several properties are checked on every cycle by assertions:
- `bufEvent` is never high two cycles in a row, and it is always caused by an accepted word.
- `running` is low whenever a fault or a finish is reported.
- The remaining-byte count stays in range.
- Each accepted word moves the offset by exactly four.
- A load clears the offset and frame position.

Some behaviours can only be shown by the bench's scenarios with a randomly gapped stream. These are the exact address sequence across the region wrap, the event position at every buffer boundary, the stop after the requested count, and the restart in mid-run.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef struct packed {
    logic load;
    logic accept;
  } sbwStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sbwState_t;
endpackage

// File: rtl/sbw_dpath.sv
module sbw_dpath
  import sbw_pkg::*;
#(
  parameter int MEM_BYTES   = 32'h100000,
  parameter int BUF_BYTES   = 32'h20000,
  parameter int FRAME_WORDS = 8,
  parameter int BLK_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  sbwStrobes_t      str,
  input  logic [31:0]      cfgBase,
  input  logic [BLK_W-1:0] cfgBlocks,
  output logic [31:0]      memAddr,
  output logic             lastWord,
  output logic             lastBlock
);
  localparam int OFF_W       = $clog2(MEM_BYTES);
  localparam int FRAME_BYTES = FRAME_WORDS * 4;
  localparam int LEFT_W      = $clog2(BUF_BYTES) + 1;
  localparam int WC_W        = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1;
  localparam logic [OFF_W-1:0]  STEP     = OFF_W'(4);
  localparam logic [LEFT_W-1:0] BUF_FULL = LEFT_W'(BUF_BYTES);
  localparam logic [LEFT_W-1:0] FR_B     = LEFT_W'(FRAME_BYTES);
  localparam logic [WC_W-1:0]   WC_LAST  = WC_W'(FRAME_WORDS - 1);

  logic [31:0]       baseQ;
  logic [OFF_W-1:0]  byteOff;
  logic [WC_W-1:0]   wordCnt;
  logic [LEFT_W-1:0] bufLeft;
  logic [BLK_W-1:0]  blocksLeft;
  logic              frameEnd;

  assign frameEnd  = (wordCnt == WC_LAST);
  assign lastWord  = frameEnd && (bufLeft == FR_B);
  assign lastBlock = (blocksLeft == BLK_W'(1));
  assign memAddr   = baseQ + 32'(byteOff);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ      <= '0;
      byteOff    <= '0;
      wordCnt    <= '0;
      bufLeft    <= BUF_FULL;
      blocksLeft <= '0;
    end else if (str.load) begin
      baseQ      <= cfgBase;
      byteOff    <= '0;
      wordCnt    <= '0;
      bufLeft    <= BUF_FULL;
      blocksLeft <= cfgBlocks;
    end else if (str.accept) begin
      byteOff <= byteOff + STEP;
      wordCnt <= frameEnd ? '0 : wordCnt + WC_W'(1);
      if (frameEnd) begin
        if (bufLeft == FR_B) begin
          bufLeft    <= BUF_FULL;
          blocksLeft <= blocksLeft - BLK_W'(1);
        end else begin
          bufLeft <= bufLeft - FR_B;
        end
      end
    end
  end

  a_r3_offset_step: assert property (@(posedge clk) disable iff (!rstN)
    (str.accept && !str.load) |=> byteOff == $past(byteOff) + STEP);
  a_r4_left_range: assert property (@(posedge clk) disable iff (!rstN)
    (bufLeft != '0) && (bufLeft <= BUF_FULL));
  a_r9_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    str.load |=> (byteOff == '0) && (wordCnt == '0) && (bufLeft == BUF_FULL));
endmodule

// File: rtl/sbw_ctrl.sv
module sbw_ctrl
  import sbw_pkg::*;
#(
  parameter int MEM_BYTES = 32'h100000,
  parameter int BLK_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [31:0]      cfgSize,
  input  logic [BLK_W-1:0] cfgBlocks,
  input  logic             sampleValid,
  input  logic             lastWord,
  input  logic             lastBlock,
  output sbwStrobes_t      str,
  output logic             bufEvent,
  output logic             running,
  output logic             finished,
  output logic             sizeFault
);
  sbwState_t state;

  assign running    = (state == ST_RUN);
  assign str.load   = start;
  assign str.accept = running && sampleValid && !start;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bufEvent  <= 1'b0;
      finished  <= 1'b0;
      sizeFault <= 1'b0;
    end else begin
      bufEvent <= 1'b0;
      if (start) begin
        if (cfgSize != 32'(MEM_BYTES)) begin
          sizeFault <= 1'b1;
          finished  <= 1'b0;
          state     <= ST_IDLE;
        end else begin
          sizeFault <= 1'b0;
          finished  <= (cfgBlocks == '0);
          state     <= (cfgBlocks == '0) ? ST_IDLE : ST_RUN;
        end
      end else if (str.accept && lastWord) begin
        bufEvent <= 1'b1;
        if (lastBlock) begin
          state    <= ST_IDLE;
          finished <= 1'b1;
        end
      end
    end
  end

  a_r4_event_single: assert property (@(posedge clk) disable iff (!rstN)
    bufEvent |=> !bufEvent);
  a_r4_event_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEvent) |-> $past(str.accept));
  a_r1_fault_idle: assert property (@(posedge clk) disable iff (!rstN)
    sizeFault |-> !running);
  a_r7_finish_idle: assert property (@(posedge clk) disable iff (!rstN)
    finished |-> !running);
endmodule

// File: rtl/sample_buf_writer.sv
module sample_buf_writer
  import sbw_pkg::*;
#(
  parameter int MEM_BYTES   = 32'h100000,
  parameter int BUF_BYTES   = 32'h20000,
  parameter int FRAME_WORDS = 8,
  parameter int BLK_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [31:0]      cfgBase,
  input  logic [31:0]      cfgSize,
  input  logic [BLK_W-1:0] cfgBlocks,
  input  logic             sampleValid,
  input  logic [31:0]      sampleData,
  output logic             memWe,
  output logic [31:0]      memAddr,
  output logic [31:0]      memData,
  output logic             bufEvent,
  output logic             running,
  output logic             finished,
  output logic             sizeFault
);
  sbwStrobes_t str;
  logic lastWord;
  logic lastBlock;

  sbw_ctrl #(.MEM_BYTES(MEM_BYTES), .BLK_W(BLK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgSize(cfgSize),
    .cfgBlocks(cfgBlocks), .sampleValid(sampleValid), .lastWord(lastWord),
    .lastBlock(lastBlock), .str(str), .bufEvent(bufEvent),
    .running(running), .finished(finished), .sizeFault(sizeFault)
  );

  sbw_dpath #(.MEM_BYTES(MEM_BYTES), .BUF_BYTES(BUF_BYTES),
              .FRAME_WORDS(FRAME_WORDS), .BLK_W(BLK_W)) u_dpath (
    .clk(clk), .rstN(rstN), .str(str), .cfgBase(cfgBase),
    .cfgBlocks(cfgBlocks), .memAddr(memAddr), .lastWord(lastWord),
    .lastBlock(lastBlock)
  );

  assign memWe   = str.accept;
  assign memData = sampleData;
endmodule

// File: tb/sim_sample_buf_writer.sv
module sim_sample_buf_writer;
  localparam int MEM_B = 256;
  localparam int BUF_B = 64;
  localparam int FRW   = 8;
  localparam int BW    = 16;
  localparam int WPB   = BUF_B / 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] cfgBase = '0;
  logic [31:0] cfgSize = '0;
  logic [BW-1:0] cfgBlocks = '0;
  logic sampleValid = 1'b0;
  logic [31:0] sampleData = '0;
  logic memWe, bufEvent, running, finished, sizeFault;
  logic [31:0] memAddr, memData;

  int checks = 0;
  int errors = 0;

  bit runE, finE, errE, evtE;
  int offE, wibE, blkE, wordsE;
  logic [31:0] baseE;

  always #10 clk = ~clk;

  sample_buf_writer #(.MEM_BYTES(MEM_B), .BUF_BYTES(BUF_B),
                      .FRAME_WORDS(FRW), .BLK_W(BW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .cfgBase(cfgBase),
    .cfgSize(cfgSize), .cfgBlocks(cfgBlocks), .sampleValid(sampleValid),
    .sampleData(sampleData), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .bufEvent(bufEvent), .running(running),
    .finished(finished), .sizeFault(sizeFault)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input logic [31:0] b, input int o);
    return b + 32'(o);
  endfunction

  task automatic cyc(input bit st, input bit v, input logic [31:0] d);
    bit weE;
    @(negedge clk);
    chk(bufEvent === evtE, "R4", 32'(bufEvent), 32'(evtE));
    chk(finished === finE, finE ? "R7" : "R5", 32'(finished), 32'(finE));
    chk(sizeFault === errE, "R1", 32'(sizeFault), 32'(errE));
    chk(running === runE, "R5", 32'(running), 32'(runE));
    start = st; sampleValid = v; sampleData = d;
    #1;
    weE = runE && v && !st;
    chk(memWe === weE, errE ? "R1" : (finE ? "R5" : "R11"), 32'(memWe), 32'(weE));
    if (weE) begin
      chk(memAddr === expAddr(baseE, offE),
          (wordsE == 0) ? "R2" : ((offE == 0) ? "R6" : "R3"),
          memAddr, expAddr(baseE, offE));
      chk(memData === d, "R3", memData, d);
    end
    evtE = 1'b0;
    if (st) begin
      if (cfgSize != 32'(MEM_B)) begin
        errE = 1; runE = 0; finE = 0;
      end else begin
        errE = 0; baseE = cfgBase; offE = 0; wibE = 0; wordsE = 0;
        blkE = int'(cfgBlocks);
        finE = (blkE == 0); runE = (blkE != 0);
      end
    end else if (weE) begin
      offE = (offE + 4) % MEM_B;
      wordsE++;
      wibE++;
      if (wibE == WPB) begin
        wibE = 0; evtE = 1; blkE--;
        if (blkE == 0) begin runE = 0; finE = 1; end
      end
    end
  endtask

  task automatic doStart(input logic [31:0] b, input logic [31:0] sz,
                         input int n);
    cfgBase = b; cfgSize = sz; cfgBlocks = BW'(n);
    cyc(1, 0, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R10: reset state
    chk({memWe, bufEvent, running, finished, sizeFault} === 5'b0, "R10",
        {27'b0, memWe, bufEvent, running, finished, sizeFault}, 0);

    // R1: wrong size refuses to start
    doStart(32'h2000_0000, 32'(MEM_B / 2), 3);
    for (int i = 0; i < 6; i++) cyc(0, 1, $urandom);

    // R2 R3 R4 R5 R6 R11: long run with random gaps, wraps the region
    doStart(32'h1000_0100, 32'(MEM_B), 6);
    for (int i = 0; i < 2000 && runE; i++) cyc(0, ($urandom % 10) < 7, $urandom);
    // R7: finished holds, later samples ignored
    for (int i = 0; i < 8; i++) cyc(0, 1, $urandom);

    // R8: zero block count
    doStart(32'h3000_0000, 32'(MEM_B), 0);
    chk(finE == 1, "R8", 32'(finE), 1);
    for (int i = 0; i < 5; i++) cyc(0, 1, $urandom);

    // R9: restart in mid-run
    doStart(32'h4000_0000, 32'(MEM_B), 3);
    for (int i = 0; i < 21; i++) cyc(0, 1, $urandom);
    doStart(32'h5000_0040, 32'(MEM_B), 1);
    for (int i = 0; i < 200 && runE; i++) cyc(0, ($urandom % 4) != 0, $urandom);
    for (int i = 0; i < 4; i++) cyc(0, 1, $urandom);

    // corner: exactly one buffer back-to-back, then fault clears finished
    doStart(32'h0, 32'(MEM_B), 1);
    for (int i = 0; i < WPB + 3; i++) cyc(0, 1, 32'(i));
    doStart(32'h0, 32'h0, 1);
    cyc(0, 0, 0);
    cyc(0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule